// File: doc/BRIEF.md
# Peripheral Output Channel Receiver

This block sits on the peripheral side of a parallel output cable driven by a host computer. The cable carries one shared word bus and two handshakes: one for data words and one for command (function) words. For each word type the block drives a request line to the host while local logic says it can take a word. It watches the matching acknowledge line, counts only a fresh 0-to-1 change of that line, and captures the bus into its output register.

Each acknowledge line passes through a synchronizer before edge detection, because the host is asynchronous to the local clock. After an acknowledged request is dropped, it is held low for a programmable recovery time before it may rise again. The host may also push a word with no request raised (a forced transfer). Such a word is captured like any other.

The captured word leaves on a valid strobe with a type tag. The strobe has no ready input and cannot be stalled: the sink must take the word in the cycle it is shown. Back-pressure is applied one level up. Dropping a local ready input keeps the matching request line from rising, so the host is not invited to send. A forced transfer bypasses this, which is the host's choice.

Top module: `outchan_receiver`

## Requirements
- R1: An acknowledge line yields one word per 0-to-1 change. A line held high yields no further word until it has been low. A line already high when reset is released yields no word.
- R2: `word_valid_o` is high for one cycle, on the third rising clock edge after the acknowledge changes. `word_o` then holds the bus value at that edge, and `word_is_func_o` is 1 for the function acknowledge and 0 for the data acknowledge.
- R3: A raised request stays high until its own acknowledge edge is detected. It falls at the same clock edge that raises `word_valid_o`.
- R4: Once a request has fallen, it stays low for at least `LOW_CYC` cycles. With ready held high, it rises again exactly `LOW_CYC+1` cycles after it fell.
- R5: A request rises only while its ready input is high. It rises at the first clock edge with ready high once recovery is complete, including straight after reset. Dropping ready while the request is high does not lower it.
- R6: A word acknowledged while its request is low (a forced transfer) is still captured, and that request stays low.
- R7: Two acknowledge pulses are both counted when separated by a single low clock cycle and each high for two cycles.
- R8: If both acknowledge edges are detected in the same cycle, only the function word is delivered (tag 1). The data edge is consumed and produces no word.
- R9: During and right after reset, `word_valid_o`, both request lines and `word_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| out_word_i | input | WORD_W | Shared word bus from the host |
| data_ack_i | input | 1 | Data acknowledge from the host (asynchronous) |
| func_ack_i | input | 1 | Function acknowledge from the host (asynchronous) |
| data_ready_i | input | 1 | Local logic can accept a data word |
| func_ready_i | input | 1 | Local logic can accept a function word |
| data_req_o | output | 1 | Data request to the host |
| func_req_o | output | 1 | Function request to the host |
| word_o | output | WORD_W | Captured word |
| word_valid_o | output | 1 | One-cycle strobe for `word_o` |
| word_is_func_o | output | 1 | 1 for a function word, 0 for a data word |

## Verification
A wrong edge-history bit shows at the ports within three cycles. It appears either as a second strobe while an acknowledge is held high, or as a missing strobe for a fresh pulse. A corrupt recovery counter shows as a request that rises too early or too late relative to the `LOW_CYC+1` mark, so the bench times that interval to the exact cycle. A broken request register shows either as a request that falls without an acknowledge, or as a request that rises while ready is low. Both are visible within a cycle.

// File: rtl/outchan_pkg.sv
package outchan_pkg;
  typedef enum logic {
    KIND_DATA = 1'b0,
    KIND_FUNC = 1'b1
  } word_kind_e;

  localparam int unsigned NUM_KINDS = 2;
endpackage

// File: rtl/ack_edge_sync.sv
module ack_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              hist_q;

  // Reset to 1 so a line already high at release never counts as an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      hist_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      hist_q  <= chain_q[LAST];
    end
  end

  assign level_o = chain_q[LAST];
  // Fresh transition gated by the settled high level.
  assign rise_o  = chain_q[LAST] & ~hist_q;

  // R1: after an edge, no new edge while the settled level stays high
  p_no_repeat_while_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o && chain_q[LAST-1]) |=> !rise_o);
endmodule

// File: rtl/req_ctrl.sv
module req_ctrl #(
  parameter int unsigned LOW_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_i,
  input  logic ack_rise_i,
  output logic req_o
);
  localparam int unsigned CW = $clog2(LOW_CYC + 1);
  localparam logic [CW-1:0] LOW_MAX = CW'(LOW_CYC);

  logic          req_q;
  logic [CW-1:0] low_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      low_cnt_q <= LOW_MAX;
    end else if (ack_rise_i) begin
      if (req_q) begin
        req_q     <= 1'b0;
        low_cnt_q <= '0;
      end
    end else if (!req_q) begin
      if (low_cnt_q != LOW_MAX) low_cnt_q <= low_cnt_q + 1'b1;
      else if (ready_i)         req_q     <= 1'b1;
    end
  end

  assign req_o = req_q;

  // Independent checker: saturating count of cycles spent low.
  logic [CW-1:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 low_run_q <= LOW_MAX;
    else if (req_o)             low_run_q <= '0;
    else if (low_run_q != LOW_MAX) low_run_q <= low_run_q + 1'b1;
  end

  // R3: request held until its acknowledge edge
  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_rise_i) |=> req_o);
  // R3: request falls on its acknowledge edge
  p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack_rise_i) |=> !req_o);
  // R4: rise only after the full recovery time
  p_min_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> (low_run_q == LOW_MAX));
  // R5: rise only with ready
  p_raise_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(ready_i));
endmodule

// File: rtl/outchan_receiver.sv
module outchan_receiver
  import outchan_pkg::*;
#(
  parameter int unsigned WORD_W  = 36,
  parameter int unsigned STAGES  = 2,
  parameter int unsigned LOW_CYC = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] out_word_i,
  input  logic              data_ack_i,
  input  logic              func_ack_i,
  input  logic              data_ready_i,
  input  logic              func_ready_i,
  output logic              data_req_o,
  output logic              func_req_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              word_is_func_o
);
  logic [NUM_KINDS-1:0] ack_line, ready_line, ack_level, ack_rise, req_line;

  assign ack_line[KIND_DATA]   = data_ack_i;
  assign ack_line[KIND_FUNC]   = func_ack_i;
  assign ready_line[KIND_DATA] = data_ready_i;
  assign ready_line[KIND_FUNC] = func_ready_i;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    ack_edge_sync #(.STAGES(STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (ack_line[k]),
      .level_o(ack_level[k]),
      .rise_o (ack_rise[k])
    );
    req_ctrl #(.LOW_CYC(LOW_CYC)) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .ready_i   (ready_line[k]),
      .ack_rise_i(ack_rise[k]),
      .req_o     (req_line[k])
    );
  end

  assign data_req_o = req_line[KIND_DATA];
  assign func_req_o = req_line[KIND_FUNC];

  // Function edge wins when both arrive together; the data edge is consumed.
  logic       take;
  word_kind_e kind;
  assign take = |ack_rise;
  assign kind = ack_rise[KIND_FUNC] ? KIND_FUNC : KIND_DATA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid_o   <= 1'b0;
      word_is_func_o <= 1'b0;
      word_o         <= '0;
    end else begin
      word_valid_o <= take;
      if (take) begin
        word_o         <= out_word_i;
        word_is_func_o <= (kind == KIND_FUNC);
      end
    end
  end

  // R2: captured word equals the bus one edge earlier
  p_word_matches_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (word_o == $past(out_word_i)));
  // R1: a data strobe is never followed by another data strobe
  p_single_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && !word_is_func_o) |=> !(word_valid_o && !word_is_func_o));
  // R1: same for function strobes
  p_single_func_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && word_is_func_o) |=> !(word_valid_o && word_is_func_o));
  // R8: a function strobe coincides with the settled function level
  p_func_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && word_is_func_o) |-> $past(ack_level[KIND_FUNC]));
endmodule

// File: tb/outchan_receiver_test.sv
module outchan_receiver_test;
  localparam int unsigned WORD_W = 36;
  localparam int unsigned LOW    = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [WORD_W-1:0] bus = '0;
  logic              data_ack = 1'b0, func_ack = 1'b0;
  logic              data_ready = 1'b0, func_ready = 1'b0;
  logic              data_req, func_req, word_valid, is_func;
  logic [WORD_W-1:0] word;

  int checks = 0, fails = 0, valid_tally = 0, func_tally = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  outchan_receiver #(.WORD_W(WORD_W), .STAGES(2), .LOW_CYC(LOW)) uut (
    .clk(clk), .rst_n(rst_n), .out_word_i(bus),
    .data_ack_i(data_ack), .func_ack_i(func_ack),
    .data_ready_i(data_ready), .func_ready_i(func_ready),
    .data_req_o(data_req), .func_req_o(func_req),
    .word_o(word), .word_valid_o(word_valid), .word_is_func_o(is_func)
  );

  always @(negedge clk) if (word_valid) begin
    valid_tally++;
    if (is_func) func_tally++;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic kreq(input logic f);
    return f ? func_req : data_req;
  endfunction

  task automatic set_ack(input logic f, input logic v);
    if (f) func_ack = v; else data_ack = v;
  endtask

  // One transfer; entered and left at a falling edge.
  task automatic xfer(input logic f, input logic forced, input logic [WORD_W-1:0] w);
    int n;
    if (!forced) begin
      if (f) func_ready = 1'b1; else data_ready = 1'b1;
      n = 0;
      while (!kreq(f) && n < 20) begin @(negedge clk); n++; end
      chk(kreq(f) == 1'b1, "R5 request raised", kreq(f), 1);
    end else begin
      chk(kreq(f) == 1'b0, "R6 request low before forced word", kreq(f), 0);
    end
    bus = w;
    set_ack(f, 1'b1);
    @(negedge clk); @(negedge clk);
    chk(word_valid == 1'b0, "R2 no strobe before third edge", word_valid, 0);
    @(negedge clk);
    chk(word_valid == 1'b1, "R2 strobe on third edge", word_valid, 1);
    chk(word == w, "R2 captured word", word, w);
    chk(is_func == f, "R2 type tag", is_func, f);
    chk(kreq(f) == 1'b0, forced ? "R6 request stays low" : "R3 request drops with strobe", kreq(f), 0);
    data_ready = 1'b0; func_ready = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(word_valid == 1'b0, "R1 held acknowledge counted once", word_valid, 0);
    end
    set_ack(f, 1'b0);
    repeat (LOW + 4) @(negedge clk);
  endtask

  // {is_func, forced, word}
  localparam logic [WORD_W+1:0] VEC [0:5] = '{
    {1'b0, 1'b0, 36'h1_2345_6789},
    {1'b1, 1'b0, 36'hF_EDCB_A987},
    {1'b0, 1'b1, 36'h0_0000_0001},
    {1'b1, 1'b1, 36'h8_0000_0000},
    {1'b0, 1'b0, 36'hF_FFFF_FFFF},
    {1'b1, 1'b0, 36'h0_0000_0000}
  };

  initial begin
    #400000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n, base;
    repeat (3) @(negedge clk);
    chk(word_valid == 1'b0, "R9 strobe low in reset", word_valid, 0);
    chk({data_req, func_req} == 2'b00, "R9 requests low in reset", {data_req, func_req}, 0);
    chk(word == '0, "R9 word cleared", word, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({data_req, func_req} == 2'b00, "R9 requests low without ready", {data_req, func_req}, 0);

    // Table walk
    for (int v = 0; v < 6; v++)
      xfer(VEC[v][WORD_W+1], VEC[v][WORD_W], VEC[v][WORD_W-1:0]);

    // R4 recovery time, R5 ready gating
    data_ready = 1'b1;
    @(negedge clk);
    chk(data_req == 1'b1, "R5 raise one edge after ready", data_req, 1);
    bus = 36'hA_5A5A_5A5A;
    data_ack = 1'b1;
    repeat (3) @(negedge clk);
    chk(data_req == 1'b0, "R3 drop on acknowledge", data_req, 0);
    n = 0;
    while (!data_req && n < 50) begin @(negedge clk); n++; end
    chk(n == LOW + 1, "R4 recovery length", n, LOW + 1);
    data_ready = 1'b0;
    repeat (5) @(negedge clk);
    chk(data_req == 1'b1, "R5 ready drop keeps request", data_req, 1);
    data_ack = 1'b0;
    repeat (2) @(negedge clk);
    data_ack = 1'b1;
    repeat (3) @(negedge clk);
    chk(data_req == 1'b0, "R3 drop on second acknowledge", data_req, 0);
    data_ack = 1'b0;
    repeat (LOW + 5) @(negedge clk);
    chk(data_req == 1'b0, "R5 no raise without ready", data_req, 0);
    data_ready = 1'b1;
    @(negedge clk);
    chk(data_req == 1'b1, "R5 raise once ready returns", data_req, 1);
    data_ready = 1'b0;
    data_ack = 1'b1;
    repeat (4) @(negedge clk);
    data_ack = 1'b0;
    repeat (LOW + 4) @(negedge clk);

    // R7 two pulses with a one-cycle low gap
    #1 base = valid_tally;
    bus = 36'h3_3333_3333;
    func_ack = 1'b1; repeat (2) @(negedge clk);
    func_ack = 1'b0; @(negedge clk);
    func_ack = 1'b1; repeat (2) @(negedge clk);
    func_ack = 1'b0; repeat (6) @(negedge clk);
    #1 chk(valid_tally - base == 2, "R7 two pulses two words", valid_tally - base, 2);

    // R8 simultaneous edges
    @(negedge clk);
    #1 base = valid_tally;
    n = func_tally;
    bus = 36'h7_0F0F_0F0F;
    data_ack = 1'b1; func_ack = 1'b1;
    repeat (3) @(negedge clk);
    chk(word_valid && is_func, "R8 function wins", {word_valid, is_func}, 2'b11);
    chk(word == 36'h7_0F0F_0F0F, "R8 word", word, 36'h7_0F0F_0F0F);
    repeat (4) @(negedge clk);
    #1 chk(valid_tally - base == 1, "R8 data edge discarded", valid_tally - base, 1);
    chk(func_tally - n == 1, "R8 single function word", func_tally - n, 1);
    data_ack = 1'b0; func_ack = 1'b0;
    repeat (4) @(negedge clk);

    // R1 line high across reset release
    rst_n = 1'b0; data_ack = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 base = valid_tally;
    repeat (8) @(negedge clk);
    #1 chk(valid_tally == base, "R1 high at reset release ignored", valid_tally - base, 0);
    data_ack = 1'b0;
    repeat (3) @(negedge clk);
    bus = 36'h5_5555_0000;
    data_ack = 1'b1;
    repeat (3) @(negedge clk);
    chk(word_valid && !is_func && word == 36'h5_5555_0000, "R1 fresh edge after low", word, 36'h5_5555_0000);
    data_ack = 1'b0;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule